// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between an on-chip requester and an external byte-wide asynchronous static RAM with 2M locations. Single-word read and write requests come in on a valid/ready handshake. The block turns each request into a sequence of active-low chip-enable, output-enable and write-enable strobes. It drives the 21-bit address lines and drives or releases the 8-bit data lines. Every strobe phase lasts a number of clock cycles set by a parameter. The integrator picks each count so that the phase is at least as long as the memory's nanosecond limit at the chosen clock period.

A write asserts chip enable first and then pulses write enable. Output enable stays high throughout, so the memory's shorter write-pulse limit applies. The block drives the data lines only from the cycle after write enable falls until the cycle after it rises. A read asserts chip enable and output enable together, with write enable high. The block samples the data lines on the last clock of the read pulse and returns the byte with a one-cycle valid pulse. After every read, the block holds off new requests for a turnaround period while the memory's output drivers switch off.

Top module: `sram_ctl`

## Requirements
- R1: After reset, sram_ce_n, sram_oe_n and sram_we_n are 1, sram_dq_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 1 only when no cycle is in progress. It is 0 from the edge of acceptance until the cycle is complete.
- R3: Address, direction and write data are registered at acceptance. Later changes on req_addr or req_wdata have no effect on the cycle that is running.
- R4: A write (req_write=1) drives sram_ce_n=0 with sram_we_n=1 for SETUP_CYC cycles. It then drives sram_we_n=0 for WE_CYC cycles, then holds sram_we_n=1 with sram_ce_n=0 for one cycle, and then raises sram_ce_n. sram_oe_n stays 1 for the whole write, and sram_we_n=0 never occurs while sram_ce_n=1.
- R5: sram_dq_oe=1 only from the cycle after sram_we_n falls through the cycle after it rises. During that window, sram_dq_out carries the accepted write data, which the memory stores at the edge where sram_we_n rises.
- R6: A read (req_write=0) drives sram_ce_n=0 and sram_oe_n=0 together for RD_CYC cycles while sram_we_n stays 1. The address is on sram_addr no later than the cycle in which sram_ce_n falls.
- R7: The read byte is sampled from sram_dq_in at the clock edge that ends the read pulse. It appears on rsp_rdata with rsp_valid=1 for exactly one cycle, RD_CYC+1 cycles after acceptance.
- R8: After a read pulse ends, all strobes stay high and req_ready stays 0 for TURN_CYC cycles. The data lines are therefore never driven while the memory may still be driving them.
- R9: All 21 address bits reach the memory unchanged, including address 0 and address 0x1FFFFF.
- R10: sram_addr stays stable for every cycle in which sram_ce_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Byte read |
| sram_addr | output | 21 | Address lines to the memory |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | 8 | Data driven toward the memory |
| sram_dq_oe | output | 1 | 1 = data lines driven by the controller |
| sram_dq_in | input | 8 | Data lines as seen from the memory |

## Verification
The behavioural memory in the bench returns a wrong byte until one full clock after output enable falls. If the read pulse were shortened or the sample taken one edge early, the wrong byte would reach rsp_rdata. The bench model flags any cycle in which the controller drives the data lines while the memory drives them or has just stopped driving them. It would catch a missing turnaround after a read, or drive enable asserted in the same cycle as write enable falls. The bench changes the request lines straight after acceptance and reads both addresses back, so a design that used the live inputs would store the byte at the wrong place. It also writes at both ends of the address range and with walking-one addresses, and it measures how long write enable stays low, so a dropped address bit or a wrong pulse count shows up.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WSET  = 3'd1,
        ST_WPUL  = 3'd2,
        ST_WHOLD = 3'd3,
        ST_RPUL  = 3'd4,
        ST_RTURN = 3'd5
    } seq_state_e;

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 2,
    parameter int RD_CYC    = 2,
    parameter int TURN_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              cap_en
);

    localparam int MAX_AB  = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
    localparam int MAX_CD  = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        seq_state_e        st;
        cnt_t              cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        st: ST_IDLE, cnt: '0, addr: '0, wdata: '0,
        ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0
    };

    seq_regs_t r_d, r_q;
    logic      last_d;

    assign last_d = (r_q.cnt == '0);

    always_comb begin
        r_d    = r_q;
        cap_en = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.ce_n  = 1'b0;
                    if (req_write) begin
                        r_d.st  = ST_WSET;
                        r_d.cnt = cnt_t'(SETUP_CYC - 1);
                    end else begin
                        r_d.st   = ST_RPUL;
                        r_d.oe_n = 1'b0;
                        r_d.cnt  = cnt_t'(RD_CYC - 1);
                    end
                end
            end
            ST_WSET: begin
                if (last_d) begin
                    r_d.st   = ST_WPUL;
                    r_d.we_n = 1'b0;
                    r_d.cnt  = cnt_t'(WE_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WPUL: begin
                r_d.dq_oe = 1'b1;
                if (last_d) begin
                    r_d.st   = ST_WHOLD;
                    r_d.we_n = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WHOLD: begin
                r_d.st    = ST_IDLE;
                r_d.ce_n  = 1'b1;
                r_d.dq_oe = 1'b0;
            end
            ST_RPUL: begin
                if (last_d) begin
                    cap_en   = 1'b1;
                    r_d.st   = ST_RTURN;
                    r_d.ce_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.cnt  = cnt_t'(TURN_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RTURN: begin
                if (last_d) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign mem_addr  = r_q.addr;
    assign ce_n      = r_q.ce_n;
    assign oe_n      = r_q.oe_n;
    assign we_n      = r_q.we_n;
    assign dq_out    = r_q.wdata;
    assign dq_oe     = r_q.dq_oe;

    // R5
    drive_window_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!we_n || !$past(we_n)));

    // R5
    drive_late_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> !dq_oe);

    // R4
    write_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!ce_n && oe_n));

    // R6
    read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (we_n && !ce_n && !dq_oe));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !$past(ce_n)) |-> $stable(mem_addr));

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !ce_n |-> !req_ready);

    // R8
    turn_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_n) |-> (ce_n && !req_ready && !dq_oe));

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_regs_t;

    cap_regs_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.valid = cap_en;
        if (cap_en) begin
            c_d.data = dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rsp_valid = c_q.valid;
    assign rsp_rdata = c_q.data;

    // R7
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 2,
    parameter int RD_CYC    = 2,
    parameter int TURN_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    logic cap_en;

    sram_ctl_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
        .WE_CYC(WE_CYC), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready),
        .mem_addr(sram_addr), .ce_n(sram_ce_n), .oe_n(sram_oe_n),
        .we_n(sram_we_n), .dq_out(sram_dq_out), .dq_oe(sram_dq_oe),
        .cap_en(cap_en)
    );

    sram_ctl_rdcap #(
        .DATA_W(DATA_W)
    ) u_rdcap (
        .clk(clk), .rst(rst),
        .cap_en(cap_en), .dq_in(sram_dq_in),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

endmodule

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

    localparam int AW = 21;
    localparam int DW = 8;
    localparam int SETUP_C = 1;
    localparam int WE_C = 2;
    localparam int RD_C = 2;
    localparam int TURN_C = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out;
    logic [DW-1:0] sram_dq_in = 8'hEE;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sram_ctl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP_C),
        .WE_CYC(WE_C), .RD_CYC(RD_C), .TURN_CYC(TURN_C)
    ) u_sram_ctl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory with timing checks ----------------
    logic [DW-1:0] mem [int unsigned];
    int  rd_age = 0;
    int  we_lo = 0;
    int  ce_lo = 0;
    bit  prev_wr = 0;
    bit  prev_ce = 0;
    bit  prev_drv = 0;
    bit  prev_we_n = 1;
    bit  prev_oe = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_dout = '0;

    function automatic logic [DW-1:0] mem_get(input logic [AW-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return '0;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            bit wr_now, drv_now;
            wr_now  = !sram_ce_n && !sram_we_n;
            drv_now = !sram_ce_n && !sram_oe_n;
            if (drv_now) begin
                rd_age++;
                sram_dq_in <= (rd_age >= 2) ? mem_get(sram_addr) : ~mem_get(sram_addr) ^ 8'h3C;
            end else begin
                rd_age = 0;
                sram_dq_in <= 8'hEE;
            end
            // R5 R8: no contention with memory outputs, including their turn-off
            if (sram_dq_oe && (drv_now || prev_drv))
                check(0, "R8 bus contention", 1, 0);
            // R5: drive only after WE fell and until one cycle after it rose
            if (sram_dq_oe && (prev_we_n && (sram_we_n || !prev_wr)))
                check(0, "R5 drive outside window", 1, 0);
            // R6: WE must stay high while output enable is low
            if (!sram_we_n && !sram_oe_n)
                check(0, "R6 WE low during read", 1, 0);
            // R4: WE low only under CE
            if (!sram_we_n && sram_ce_n)
                check(0, "R4 WE low without CE", 1, 0);
            // R10: address stable while CE low
            if (prev_ce && !sram_ce_n && sram_addr != prev_addr)
                check(0, "R10 address moved", int'(sram_addr), int'(prev_addr));
            if (!sram_ce_n) ce_lo++;
            if (wr_now) begin
                we_lo++;
                if (!sram_oe_n) check(0, "R4 OE low during write", 0, 1);
            end
            if (prev_wr && !wr_now) begin
                check(we_lo == WE_C, "R4 WE pulse cycles", we_lo, WE_C);
                check(ce_lo - 1 == SETUP_C + WE_C, "R4 CE before write end", ce_lo - 1, SETUP_C + WE_C);
                check(prev_oe == 1'b1, "R5 data set up before write end", prev_oe, 1);
                mem[int'(prev_addr)] = prev_dout;
                we_lo = 0;
            end
            if (sram_ce_n) ce_lo = 0;
            prev_wr   = wr_now;
            prev_ce   = !sram_ce_n;
            prev_drv  = drv_now;
            prev_we_n = sram_we_n;
            prev_oe   = sram_dq_oe;
            prev_addr = sram_addr;
            prev_dout = sram_dq_out;
        end
    end

    // ---------------- request helpers ----------------
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        issue(1'b1, a, d);
        // R2 and R4: busy, CE low, WE still high, OE high in first cycle
        check(!req_ready, "R2 ready low after accept", req_ready, 0);
        check(!sram_ce_n && sram_we_n && sram_oe_n, "R4 setup phase strobes",
              {sram_ce_n, sram_oe_n, sram_we_n}, 3'b011);
        check(!sram_dq_oe, "R5 bus released in setup", sram_dq_oe, 0);
        for (int k = 0; k < 40 && !req_ready; k++) @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        int k;
        int j;
        issue(1'b0, a, 8'h00);
        check(!sram_ce_n && !sram_oe_n && sram_we_n, "R6 read strobes",
              {sram_ce_n, sram_oe_n, sram_we_n}, 3'b001);
        check(sram_addr == a, "R9 address on pins", int'(sram_addr), int'(a));
        k = 1;
        while (!rsp_valid && k < 40) begin
            @(negedge clk);
            k++;
        end
        check(k == RD_C + 1, "R7 response latency", k, RD_C + 1);
        check(rsp_rdata == exp, "R7 read data", rsp_rdata, exp);
        j = 0;
        while (!req_ready && j < 40) begin
            check(sram_ce_n && sram_oe_n && sram_we_n, "R8 strobes high in turnaround",
                  {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
            @(negedge clk);
            j++;
            if (j == 1) check(!rsp_valid, "R7 single-cycle response", rsp_valid, 0);
        end
        check(j == TURN_C, "R8 turnaround length", j, TURN_C);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check(req_ready, "R1 ready", req_ready, 1);
        check(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes high",
              {sram_ce_n, sram_oe_n, sram_we_n}, 3'b111);
        check(!sram_dq_oe, "R1 bus released", sram_dq_oe, 0);
        check(!rsp_valid, "R1 no response", rsp_valid, 0);
    endtask

    task automatic t_basic();
        do_write(21'h00010, 8'h5A);
        do_read(21'h00010, 8'h5A);
        do_read(21'h00777, 8'h00);
    endtask

    task automatic t_range_ends();
        // R9
        do_write(21'h000000, 8'hFF);
        do_write(21'h1FFFFF, 8'h00);
        do_write(21'h1FFFFE, 8'hA5);
        do_read(21'h000000, 8'hFF);
        do_read(21'h1FFFFF, 8'h00);
        do_read(21'h1FFFFE, 8'hA5);
    endtask

    task automatic t_overwrite();
        do_write(21'h0ABCD, 8'h11);
        do_write(21'h0ABCD, 8'hC3);
        do_read(21'h0ABCD, 8'hC3);
    endtask

    task automatic t_late_change();
        // R3: request lines change right after acceptance
        issue(1'b1, 21'h03030, 8'h77);
        req_addr  = 21'h04040;
        req_wdata = 8'h99;
        for (int k = 0; k < 40 && !req_ready; k++) @(negedge clk);
        do_read(21'h03030, 8'h77);
        do_read(21'h04040, 8'h00);
        check(1'b1, "R3 inputs after accept ignored", 0, 0);
    endtask

    task automatic t_turnaround();
        // R8: read immediately followed by write, then read
        do_write(21'h00100, 8'h3C);
        do_read(21'h00100, 8'h3C);
        do_write(21'h00101, 8'hC3);
        do_read(21'h00101, 8'hC3);
        do_read(21'h00100, 8'h3C);
    endtask

    task automatic t_walking();
        for (int i = 0; i < AW; i++) begin
            do_write(21'(1 << i), 8'(i * 37 + 5));
        end
        for (int i = 0; i < AW; i++) begin
            do_read(21'(1 << i), 8'(i * 37 + 5));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_range_ends();
        t_overwrite();
        t_late_change();
        t_turnaround();
        t_walking();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule